// File: doc/BRIEF.md
# Audio Codec Power-Up Configuration Master

This block brings a write-only audio codec out of reset by sending it a fixed series of register writes over a two-wire serial bus with open-drain signalling. After a single start pulse it reads each entry of a small built-in table, turns the entry into a three-byte write frame, and shifts that frame out most significant bit first. It frames each write with a start condition and a stop condition. After every byte it releases the data line for one clock and checks for the codec's acknowledge.

Neither line is ever driven high. Each output only asks for its line to be pulled low, and an external pull-up sets the high level. The bit rate comes from a clock-divider parameter. When all table entries have been written and acknowledged, the block raises `done`. If the codec fails to acknowledge any byte, the block closes the bus with a stop condition, raises `error` and sends nothing more. A later start pulse runs the whole table again from its first entry.

Top module: `codec_cfg_master`

## Requirements
- R1: Out of reset, `scl_pull` and `sda_pull` are 0 (both lines released), and `done` and `error` are 0.
- R2: A start pulse writes five entries in this fixed order, as (register, 9-bit value): (0x0F, 0x000) reset, (0x06, 0x000) power control, (0x04, 0x014) analog routing, (0x07, 0x042) interface format with master mode, (0x08, 0x00E) sampling with an 8 kHz converter rate. After the last acknowledged write, `done` becomes 1.
- R3: Each write is exactly three bytes, sent MSB first. Byte one is 0x68: device address 0x34 in bits 7..1 and a write bit of 0. Byte two is the register address in bits 7..1 and value bit 8 in bit 0. Byte three is value bits 7..0.
- R4: Each write opens with SDA falling while SCL is high and closes with SDA rising while SCL is high. Both happen exactly once per write, and SDA changes at no other time while SCL is high.
- R5: Inside a byte, SCL rising edges are 4*DIV clock cycles apart, and SCL stays high for 2*DIV cycles.
- R6: During the ninth clock of every byte the block releases SDA. It treats SDA low at that point as an acknowledge.
- R7: If SDA is high in an acknowledge clock, the block sends a stop condition right after that byte, sets `error` to 1, leaves `done` at 0 and starts no further write.
- R8: A start pulse that arrives while a sequence is running has no effect: the running sequence ends with exactly five writes.
- R9: A start pulse after `done` or `error` clears both flags and runs the sequence again from the first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the configuration sequence |
| sda_in | input | 1 | Sensed level of the serial data line |
| scl_pull | output | 1 | 1 pulls the serial clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the serial data line low, 0 releases it |
| done | output | 1 | All entries written and acknowledged |
| error | output | 1 | A byte was not acknowledged and the sequence was aborted |

## Verification
A wrong table index or shift position appears as a wrong byte value within the next eight bit times, and a miscount of bit slots appears as a missing or extra clock before the next stop. If the phase counter slips, SDA moves while SCL is high at once, and the checker catches that edge in the same cycle. If an acknowledge is sampled in the wrong phase or ignored, the bus is not cut short after a refused byte and `error` does not rise within one quarter-bit of the stop. A loss of run state shows up as a sixth start condition or as one missing before `done`.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

  localparam logic [6:0] DEV_ADDR    = 7'h34;
  localparam int         NUM_ENTRIES = 5;
  localparam int         FRAME_BYTES = 3;
  localparam int         FRAME_W     = FRAME_BYTES * 8;
  localparam int         SLOTS_PER_BYTE = 9;

  typedef struct packed {
    logic [6:0] reg_addr;
    logic [8:0] value;
  } cfg_entry_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BITS  = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  // Power-up table: position in the list is the order of writes
  function automatic cfg_entry_t init_entry(input int idx);
    cfg_entry_t e;
    case (idx)
      0:       e = {7'h0F, 9'h000};   // reset register
      1:       e = {7'h06, 9'h000};   // power control, all blocks on
      2:       e = {7'h04, 9'h014};   // analog routing
      3:       e = {7'h07, 9'h042};   // interface format, master mode
      4:       e = {7'h08, 9'h00E};   // sampling control, 8 kHz
      default: e = {7'h0F, 9'h000};
    endcase
    return e;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input cfg_entry_t e);
    return {DEV_ADDR, 1'b0, e.reg_addr, e.value};
  endfunction

  // Slot 8 of each group of nine is the acknowledge clock
  function automatic logic is_ack_slot(input int slot);
    return (slot % SLOTS_PER_BYTE) == (SLOTS_PER_BYTE - 1);
  endfunction

  // Position of a data slot inside the frame, counted from the MSB
  function automatic int data_index(input int slot);
    return slot - (slot / SLOTS_PER_BYTE);
  endfunction

endpackage

// File: rtl/codec_cfg_tick.sv
module codec_cfg_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(DIV + 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_W'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/codec_cfg_rom.sv
module codec_cfg_rom
  import codec_cfg_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [FRAME_W-1:0] frame
);
  always_comb begin
    frame = build_frame(init_entry(int'(idx)));
  end
endmodule

// File: rtl/codec_cfg_shifter.sv
module codec_cfg_shifter
  import codec_cfg_pkg::*;
#(
  parameter int BYTES = FRAME_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 go,
  input  logic [BYTES*8-1:0]   frame,
  input  logic                 sda_in,
  output logic                 scl_pull,
  output logic                 sda_pull,
  output logic                 active,
  output logic                 fin,
  output logic                 fin_nack,
  output logic                 ack_slot,
  output logic                 cond_phase
);
  localparam int FW     = BYTES * 8;
  localparam int SLOTS  = BYTES * SLOTS_PER_BYTE;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int POS_W  = $clog2(FW);

  phase_t            ph;
  logic [1:0]        q;
  logic [SLOT_W-1:0] slot;
  logic              nack_q;
  logic [FW-1:0]     frame_q;
  logic [POS_W-1:0]  bit_pos;
  logic              cur_bit;
  logic              last_slot;

  assign active     = (ph != PH_IDLE);
  assign cond_phase = (ph == PH_START) || (ph == PH_STOP);
  assign ack_slot   = (ph == PH_BITS) && is_ack_slot(int'(slot));
  assign last_slot  = (slot == SLOT_W'(SLOTS - 1));

  always_comb begin
    bit_pos = '0;
    if (!is_ack_slot(int'(slot)))
      bit_pos = POS_W'(FW - 1 - data_index(int'(slot)));
    cur_bit = frame_q[bit_pos];
  end

  // Line requests per quarter-bit phase
  always_comb begin
    scl_pull = 1'b0;
    sda_pull = 1'b0;
    case (ph)
      PH_START: begin
        scl_pull = (q >= 2'd2);
        sda_pull = (q >= 2'd1);
      end
      PH_BITS: begin
        scl_pull = (q == 2'd0) || (q == 2'd3);
        sda_pull = ack_slot ? 1'b0 : !cur_bit;
      end
      PH_STOP: begin
        scl_pull = (q == 2'd0);
        sda_pull = (q != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      q        <= '0;
      slot     <= '0;
      nack_q   <= 1'b0;
      frame_q  <= '0;
      fin      <= 1'b0;
      fin_nack <= 1'b0;
    end else begin
      fin      <= 1'b0;
      fin_nack <= 1'b0;
      if (ph == PH_IDLE) begin
        if (go) begin
          ph      <= PH_START;
          q       <= '0;
          slot    <= '0;
          nack_q  <= 1'b0;
          frame_q <= frame;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (ph)
          PH_START: if (q == 2'd3) ph <= PH_BITS;
          PH_BITS: begin
            if (q == 2'd2 && ack_slot) nack_q <= sda_in;
            if (q == 2'd3) begin
              if ((ack_slot && nack_q) || last_slot) ph <= PH_STOP;
              else slot <= slot + SLOT_W'(1);
            end
          end
          PH_STOP: if (q == 2'd3) begin
            ph       <= PH_IDLE;
            fin      <= 1'b1;
            fin_nack <= nack_q;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/codec_cfg_master.sv
module codec_cfg_master
  import codec_cfg_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic done,
  output logic error
);
  localparam int N     = NUM_ENTRIES;
  localparam int IDX_W = $clog2(N);

  logic               running;
  logic [IDX_W-1:0]   idx;
  logic               eng_go;
  logic               eng_active;
  logic               eng_fin;
  logic               eng_nack;
  logic               eng_tick;
  logic               ack_slot;
  logic               cond_phase;
  logic               last_entry;
  logic [FRAME_W-1:0] frame;

  assign last_entry = (idx == IDX_W'(N - 1));

  codec_cfg_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_active),
    .tick  (eng_tick)
  );

  codec_cfg_rom #(.IDX_W(IDX_W)) u_rom (
    .idx   (idx),
    .frame (frame)
  );

  codec_cfg_shifter #(.BYTES(FRAME_BYTES)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (eng_tick),
    .go         (eng_go),
    .frame      (frame),
    .sda_in     (sda_in),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .active     (eng_active),
    .fin        (eng_fin),
    .fin_nack   (eng_nack),
    .ack_slot   (ack_slot),
    .cond_phase (cond_phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      eng_go  <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      eng_go <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          idx     <= '0;
          eng_go  <= 1'b1;
          done    <= 1'b0;
          error   <= 1'b0;
        end
      end else if (eng_fin) begin
        if (eng_nack) begin
          running <= 1'b0;
          error   <= 1'b1;
        end else if (last_entry) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx    <= idx + IDX_W'(1);
          eng_go <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/codec_cfg_master_chk.sv
module codec_cfg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_pull,
  input logic sda_pull,
  input logic done,
  input logic error,
  input logic eng_go,
  input logic eng_active,
  input logic eng_fin,
  input logic eng_nack,
  input logic last_entry,
  input logic cond_phase
);
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // SDA may move under a high SCL only in a start or stop phase
  assert_sda_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull))) |-> cond_phase);

  assert_error_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(eng_fin && eng_nack));

  assert_done_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(eng_fin && !eng_nack && last_entry));

  assert_go_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> !eng_active);

  assert_bus_free_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fin |-> (!scl_pull && !sda_pull));
endmodule

bind codec_cfg_master codec_cfg_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .done       (done),
  .error      (error),
  .eng_go     (eng_go),
  .eng_active (eng_active),
  .eng_fin    (eng_fin),
  .eng_nack   (eng_nack),
  .last_entry (last_entry),
  .cond_phase (cond_phase)
);

// File: tb/codec_cfg_master_tb.sv
module codec_cfg_master_tb;
  localparam int DIV = 4;
  localparam int NE  = 5;
  localparam int MAXF = 8;

  // Expected writes: {register[6:0], value[8:0]}
  localparam logic [15:0] EXP_TABLE [NE] = '{
    {7'h0F, 9'h000}, {7'h06, 9'h000}, {7'h04, 9'h014},
    {7'h07, 9'h042}, {7'h08, 9'h00E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ack_drv = 1'b0;
  logic scl_pull, sda_pull, done, error;
  wire  sda_line = !(sda_pull || ack_drv);

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // bus monitor / slave state
  logic [7:0] got_b [MAXF][4];
  int got_n [MAXF];
  int frames, starts, stops, per_bad, hi_bad, ack_bad, total, nack_at;
  int bitcnt, last_rise;
  logic in_frame = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] sh;

  always #5 clk = !clk;

  codec_cfg_master #(.DIV(DIV)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sda_in   (sda_line),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .done     (done),
    .error    (error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log(input int nk);
    frames = 0; starts = 0; stops = 0; per_bad = 0; hi_bad = 0;
    ack_bad = 0; total = 0; nack_at = nk;
    for (int i = 0; i < MAXF; i++) got_n[i] = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || error) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic check_full_run(input string req);
    check(frames == NE, req, "write count", frames, NE);
    check(done == 1'b1 && error == 1'b0, req, "done/error", {done, error}, 2'b10);
    for (int i = 0; i < NE; i++) begin
      logic [15:0] e = EXP_TABLE[i];
      logic [23:0] exp_w = {8'h68, e[15:9], e[8], e[7:0]};
      logic [23:0] act_w = {got_b[i][0], got_b[i][1], got_b[i][2]};
      check(got_n[i] == 3, "R3", "bytes per write", got_n[i], 3);
      check(act_w == exp_w, "R2 R3", "write bytes", int'(act_w), int'(exp_w));
    end
  endtask

  // Bus-side codec model: decodes conditions, collects bytes, acknowledges
  initial begin : slave_model
    forever begin
      logic scl_l, sda_l;
      @(negedge clk);
      cyc++;
      scl_l = !scl_pull;
      sda_l = sda_line;
      if (p_scl && scl_l && p_sda && !sda_l) begin
        starts++;
        in_frame = 1'b1;
        bitcnt = 0;
      end else if (p_scl && scl_l && !p_sda && sda_l) begin
        stops++;
        if (in_frame && frames < MAXF - 1) frames++;
        in_frame = 1'b0;
      end
      if (in_frame && !p_scl && scl_l) begin
        if (bitcnt > 0 && (cyc - last_rise) != 4 * DIV) per_bad++;
        if (bitcnt < 8) sh = {sh[6:0], sda_l};
        else if (sda_pull) ack_bad++;
        last_rise = cyc;
        bitcnt++;
      end
      if (in_frame && p_scl && !scl_l && bitcnt > 0) begin
        if ((cyc - last_rise) != 2 * DIV) hi_bad++;
        if (bitcnt == 8) begin
          if (got_n[frames] < 4) got_b[frames][got_n[frames]] = sh;
          got_n[frames]++;
          ack_drv = (total != nack_at);
          total++;
        end else if (bitcnt == 9) begin
          ack_drv = 1'b0;
          bitcnt = 0;
        end
      end
      p_scl = scl_l;
      p_sda = sda_l;
    end
  end

  initial begin : watchdog
    wait (cyc > 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    clear_log(-1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_pull == 1'b0, "R1", "scl_pull in reset", scl_pull, 0);
    check(sda_pull == 1'b0, "R1", "sda_pull in reset", sda_pull, 0);
    check(done == 1'b0 && error == 1'b0, "R1", "flags in reset", {done, error}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!scl_pull && !sda_pull && !done && !error, "R1", "idle after reset",
          {scl_pull, sda_pull, done, error}, 0);

    // Full sequence, table walked by one loop (R2, R3)
    clear_log(-1);
    pulse_start();
    wait_end();
    check_full_run("R2");
    check(starts == NE && stops == NE, "R4", "start/stop count", starts * 16 + stops, NE * 17);
    check(per_bad == 0, "R5", "scl period errors", per_bad, 0);
    check(hi_bad == 0, "R5", "scl high time errors", hi_bad, 0);
    check(ack_bad == 0, "R6", "sda held in ack clock", ack_bad, 0);

    // R8: start during a running sequence is ignored; R9: rerun after done
    clear_log(-1);
    pulse_start();
    check(done == 1'b0, "R9", "done cleared by new start", done, 0);
    repeat (700) @(negedge clk);
    pulse_start();
    wait_end();
    check(starts == NE, "R8", "start conditions with extra pulse", starts, NE);
    check_full_run("R8");

    // R7: refuse byte 7 (second byte of third write)
    clear_log(7);
    pulse_start();
    wait_end();
    check(error == 1'b1 && done == 1'b0, "R7", "flags after nack", {done, error}, 1);
    check(frames == 3, "R7", "writes before abort", frames, 3);
    check(got_n[2] == 2, "R7", "bytes in aborted write", got_n[2], 2);
    check(stops == 3, "R7", "stop after refused byte", stops, 3);
    repeat (2000) @(negedge clk);
    check(starts == 3, "R7", "no writes after abort", starts, 3);
    check(!scl_pull && !sda_pull, "R7", "bus released after abort", {scl_pull, sda_pull}, 0);

    // R7: refuse the device address byte of the first write
    clear_log(0);
    pulse_start();
    wait_end();
    check(error == 1'b1 && frames == 1 && got_n[0] == 1, "R7", "nack on first byte",
          {error, 4'(frames), 4'(got_n[0])}, 9'h111);

    // R9: restart after error clears the flag and rewrites everything
    clear_log(-1);
    pulse_start();
    check(error == 1'b0, "R9", "error cleared by new start", error, 0);
    wait_end();
    check_full_run("R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule